// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns an asynchronous serial line into bytes. It runs on the system clock and takes its sampling rate from a one-cycle enable pulse, `smp_en`. Each pulse is one sampling tick. A bit lasts a programmable number of ticks. That number is chosen from a fixed set that includes odd and non-power-of-two values, so a coarse baud generator can still hit a target rate closely. The block takes one sample per bit. By default that sample is at the centre of the bit. A signed, clamped offset can move it earlier or later when the integer ratio leaves a known skew.

The serial input first passes through a two-stage synchronizer. A frame starts on a falling edge, and the start bit is then confirmed at the sampling point. Data bits are assembled least significant bit first, and the parity and stop bits are then checked. The received byte is presented with a one-clock strobe, together with a parity-error flag and a framing-error flag. All three outputs hold until the next character completes.

While the receiver is disabled it ignores the line. After it is enabled, it waits for a full frame of idle line before it accepts a start bit.

Top module: `uart_os_rx`

## Requirements
- R1: `cfg_ratio` selects the number of ticks per bit: code 0=5, 1=7, 2=11, 3=13, 4=16, 5=17, 6=19, 7=27. All sampling and state changes happen only on clocks where `smp_en` is high.
- R2: A start is detected when the synchronized line is high at one tick and low at the next. It is confirmed by sampling low at the sampling point. If that sample is high, the receiver returns to idle and produces no output.
- R3: The sampling point, counted in ticks, is `clamp((ratio-1)/2 + s, 0, ratio-1)`. Index 0 is the tick at which the low line was first seen. `s` is `cfg_shift` read as two's complement (-8..+7) when `cfg_shift_en`=1, and 0 otherwise. Every later bit is sampled at the same index within its own bit.
- R4: Data bits arrive least significant bit first. With `cfg_len7`=1 the character has 7 bits and `rx_data[7]` is 0. With `cfg_len7`=0 it has 8 bits.
- R5: A parity bit follows the data when `cfg_par_en` or `cfg_par_odd` is set. Parity is odd when `cfg_par_odd`=1 and even otherwise. `rx_perr` is 1 when the data and parity bits together break the selected sense. It is 0 when parity is off.
- R6: `cfg_stop2` selects two stop bits instead of one. `rx_ferr` is 1 if the first stop bit is sampled low, or if two stop bits are selected and the second is sampled low.
- R7: `rx_valid` is high for exactly one clock per character. `rx_data`, `rx_perr` and `rx_ferr` change only with it and then hold. After reset all outputs are 0.
- R8: While `rx_en` is low, no character is received and any character in progress is dropped.
- R9: After `rx_en` rises, a start is accepted only once the line has been seen high on `ratio × (1 + data bits + parity bit + stop bits)` consecutive ticks.
- R10: All configuration inputs are captured when the start edge is detected. Changes made during a character affect only the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd | input | 1 | Asynchronous serial line, idle high |
| smp_en | input | 1 | Sampling tick, one clock wide |
| rx_en | input | 1 | Receiver enable |
| cfg_len7 | input | 1 | 1: 7 data bits, 0: 8 data bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity (also turns parity on) |
| cfg_stop2 | input | 1 | Two stop bits |
| cfg_ratio | input | 3 | Ticks-per-bit code |
| cfg_shift | input | 4 | Signed sampling-point offset |
| cfg_shift_en | input | 1 | Apply the offset |
| rx_data | output | 8 | Received character |
| rx_valid | output | 1 | Character strobe |
| rx_perr | output | 1 | Parity error of the last character |
| rx_ferr | output | 1 | Framing error of the last character |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge. They place no limit on the line, the tick spacing or the configuration, because strobe width, output hold, silence while disabled and tick alignment must hold for any stimulus. The bench pulses `smp_en` every fourth clock and changes `rxd` only half a clock after a tick. The synchronizer therefore delivers each new level before the next tick, and every bit fills exactly `ratio` tick slots. The offset tests drive each bit to its wrong level for part of its slots, so the sampled value shows where the sampling point actually lies.

// File: rtl/uart_os_rx_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the oversampling receiver.
// Assumes ratio values never exceed 27, so they fit in RATIO_W bits.
package uart_os_rx_pkg;
    localparam int RATIO_W = 5;
    localparam int GUARD_W = 9;
    localparam int DATA_W  = 8;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2
    } rx_state_t;

    // Decode the ratio select code into ticks per bit.
    function automatic logic [RATIO_W-1:0] ratio_of(input logic [2:0] code);
        case (code)
            3'd0:    return RATIO_W'(5);
            3'd1:    return RATIO_W'(7);
            3'd2:    return RATIO_W'(11);
            3'd3:    return RATIO_W'(13);
            3'd4:    return RATIO_W'(16);
            3'd5:    return RATIO_W'(17);
            3'd6:    return RATIO_W'(19);
            default: return RATIO_W'(27);
        endcase
    endfunction

    // Centre index plus optional signed offset, clamped to the bit period.
    function automatic logic [RATIO_W-1:0] sample_point(input logic [RATIO_W-1:0] ratio,
                                                        input logic signed [3:0] shift,
                                                        input logic use_shift);
        int pos;
        int last;
        last = int'(ratio) - 1;
        pos  = last / 2 + (use_shift ? int'(shift) : 0);
        if (pos < 0)
            pos = 0;
        if (pos > last)
            pos = last;
        return RATIO_W'(pos);
    endfunction
endpackage

// File: rtl/uart_os_rx_sync.sv
`timescale 1ns/1ps
// Line synchronizer and tick-based falling-edge detector.
// Assumes STAGES >= 2; the line idles high, so all flops reset to 1.
module uart_os_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd,
    input  logic tick,
    output logic line,
    output logic fall
);
    logic [STAGES-1:0] pipe;
    logic              prev;

    // Move the asynchronous line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pipe <= '1;
        else
            pipe <= {pipe[STAGES-2:0], rxd};
    end

    // Remember the level seen at the previous tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev <= 1'b1;
        else if (tick)
            prev <= line;
    end

    assign line = pipe[STAGES-1];
    assign fall = tick & prev & ~line;
endmodule

// File: rtl/uart_os_rx_guard.sv
`timescale 1ns/1ps
// Idle qualifier: after enable, requires `need` consecutive high ticks
// before start edges are trusted. Stays armed until the enable drops.
module uart_os_rx_guard #(
    parameter int GW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic          tick,
    input  logic          line,
    input  logic [GW-1:0] need,
    output logic          armed
);
    logic [GW-1:0] run;

    // Count the run of high ticks and arm once it covers a frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en) begin
            run   <= '0;
            armed <= 1'b0;
        end else if (tick && !armed) begin
            if (!line)
                run <= '0;
            else if (run >= need - GW'(1))
                armed <= 1'b1;
            else
                run <= run + GW'(1);
        end
    end
endmodule

// File: rtl/uart_os_rx_frame.sv
`timescale 1ns/1ps
// Frame engine: tick counter, start confirmation, data shift, parity and
// stop checks. The configuration is captured at the start edge.
module uart_os_rx_frame
    import uart_os_rx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_en,
    input  logic               tick,
    input  logic               line,
    input  logic               fall,
    input  logic               armed,
    input  logic [RATIO_W-1:0] ratio,
    input  logic [RATIO_W-1:0] point,
    input  logic               len7,
    input  logic               par_on,
    input  logic               par_odd,
    input  logic               stop2,
    output logic [DATA_W-1:0]  rx_data,
    output logic               rx_valid,
    output logic               rx_perr,
    output logic               rx_ferr
);
    rx_state_t          st;
    logic [RATIO_W-1:0] cnt, l_ratio, l_point;
    logic               l_len7, l_par, l_odd, l_stop2;
    logic [2:0]         bitn;
    logic [DATA_W-1:0]  shreg;
    logic               par_acc, ferr_acc;
    logic               at_point, finishing, ferr_now;
    logic [DATA_W-1:0]  data_now;

    // Decode the sample instant and the end-of-frame results.
    always_comb begin
        at_point  = tick && (st != ST_IDLE) && (cnt == l_point);
        finishing = at_point && ((st == ST_STOP2) || (st == ST_STOP1 && !l_stop2));
        ferr_now  = ((st == ST_STOP2) ? ferr_acc : 1'b0) | ~line;
        data_now  = l_len7 ? {1'b0, shreg[DATA_W-1:1]} : shreg;
    end

    // Sequence the frame, one decision per sampling point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
            cnt <= '0;
            l_ratio <= RATIO_W'(5);
            l_point <= '0;
            l_len7 <= 1'b0;
            l_par <= 1'b0;
            l_odd <= 1'b0;
            l_stop2 <= 1'b0;
            bitn <= '0;
            shreg <= '0;
            par_acc <= 1'b0;
            ferr_acc <= 1'b0;
        end else if (!rx_en) begin
            st <= ST_IDLE;
        end else if (tick) begin
            if (st == ST_IDLE) begin
                if (fall && armed) begin
                    l_ratio  <= ratio;
                    l_point  <= point;
                    l_len7   <= len7;
                    l_par    <= par_on;
                    l_odd    <= par_odd;
                    l_stop2  <= stop2;
                    cnt      <= RATIO_W'(1);
                    bitn     <= '0;
                    par_acc  <= 1'b0;
                    ferr_acc <= 1'b0;
                    st       <= (point == '0) ? ST_DATA : ST_START;
                end
            end else begin
                cnt <= (cnt == l_ratio - RATIO_W'(1)) ? '0 : cnt + RATIO_W'(1);
                if (at_point) begin
                    unique case (st)
                        ST_START: st <= line ? ST_IDLE : ST_DATA;
                        ST_DATA: begin
                            shreg   <= {line, shreg[DATA_W-1:1]};
                            par_acc <= par_acc ^ line;
                            bitn    <= bitn + 3'd1;
                            if (bitn == (l_len7 ? 3'd6 : 3'd7))
                                st <= l_par ? ST_PAR : ST_STOP1;
                        end
                        ST_PAR: begin
                            par_acc <= par_acc ^ line;
                            st      <= ST_STOP1;
                        end
                        ST_STOP1: begin
                            ferr_acc <= ~line;
                            st       <= l_stop2 ? ST_STOP2 : ST_IDLE;
                        end
                        ST_STOP2: st <= ST_IDLE;
                        default:  st <= ST_IDLE;
                    endcase
                end
            end
        end
    end

    // Publish the character and its flags at the last stop sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_valid <= 1'b0;
            rx_perr  <= 1'b0;
            rx_ferr  <= 1'b0;
        end else begin
            rx_valid <= rx_en && finishing;
            if (rx_en && finishing) begin
                rx_data <= data_now;
                rx_perr <= l_par & (par_acc ^ l_odd);
                rx_ferr <= ferr_now;
            end
        end
    end
endmodule

// File: rtl/uart_os_rx.sv
`timescale 1ns/1ps
// Oversampling asynchronous receiver top: decodes the configuration and
// connects the synchronizer, the idle guard and the frame engine.
// Assumes smp_en is a clock-enable pulse at the chosen tick rate.
module uart_os_rx
    import uart_os_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    input  logic       smp_en,
    input  logic       rx_en,
    input  logic       cfg_len7,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_stop2,
    input  logic [2:0] cfg_ratio,
    input  logic [3:0] cfg_shift,
    input  logic       cfg_shift_en,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       rx_perr,
    output logic       rx_ferr
);
    logic [RATIO_W-1:0] ratio, point;
    logic [3:0]         frame_bits;
    logic [GUARD_W-1:0] need;
    logic               par_on, line, fall, armed;

    // Derive tick ratio, sample index and idle-guard length from the config.
    always_comb begin
        par_on     = cfg_par_en | cfg_par_odd;
        ratio      = ratio_of(cfg_ratio);
        point      = sample_point(ratio, $signed(cfg_shift), cfg_shift_en);
        frame_bits = 4'd2 + (cfg_len7 ? 4'd7 : 4'd8) + {3'b000, par_on} + {3'b000, cfg_stop2};
        need       = GUARD_W'(ratio) * GUARD_W'(frame_bits);
    end

    uart_os_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick(smp_en), .line(line), .fall(fall)
    );

    uart_os_rx_guard #(.GW(GUARD_W)) u_guard (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tick(smp_en), .line(line),
        .need(need), .armed(armed)
    );

    uart_os_rx_frame u_frame (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tick(smp_en), .line(line),
        .fall(fall), .armed(armed), .ratio(ratio), .point(point), .len7(cfg_len7),
        .par_on(par_on), .par_odd(cfg_par_odd), .stop2(cfg_stop2),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_perr(rx_perr), .rx_ferr(rx_ferr)
    );
endmodule

// File: rtl/uart_os_rx_chk.sv
`timescale 1ns/1ps
// Port-level checker for the receiver, attached by bind.
// Assumes rst_n is low on at least one clock edge before use.
module uart_os_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       smp_en,
    input logic       rx_en,
    input logic [7:0] rx_data,
    input logic       rx_valid,
    input logic       rx_perr,
    input logic       rx_ferr
);
    // R7: the strobe is never wider than one clock.
    p_single_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R7: outputs change only together with the strobe.
    p_hold_outputs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> ($stable(rx_data) && $stable(rx_perr) && $stable(rx_ferr)));

    // R8: nothing is delivered while disabled.
    p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !rx_valid);

    // R1: a character only completes on a sampling tick.
    p_tick_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(smp_en));
endmodule

bind uart_os_rx uart_os_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .rx_en(rx_en),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_perr(rx_perr), .rx_ferr(rx_ferr)
);

// File: tb/uart_os_rx_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the frame driver queues the expected character, and a
// monitor compares each strobe against the head of the queue.
module uart_os_rx_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rxd = 1'b1;
    logic rx_en = 1'b0;
    logic cfg_len7 = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
    logic [2:0] cfg_ratio = 3'd4;
    logic [3:0] cfg_shift = 4'd0;
    logic cfg_shift_en = 1'b0;
    logic smp_en;
    logic [7:0] rx_data;
    logic rx_valid, rx_perr, rx_ferr;
    logic [1:0] div = 2'd0;

    int checks = 0;
    int errors = 0;
    int nvalid = 0;
    int cyc = 0;

    typedef struct packed {
        logic [7:0] d;
        logic       perr;
        logic       ferr;
    } exp_t;
    exp_t  expq[$];
    string tagq[$];

    always #4 clk = ~clk;

    // Sampling tick on every fourth clock.
    always @(posedge clk) div <= div + 2'd1;
    assign smp_en = (div == 2'd3);

    uart_os_rx dut_i (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .smp_en(smp_en), .rx_en(rx_en),
        .cfg_len7(cfg_len7), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop2(cfg_stop2), .cfg_ratio(cfg_ratio), .cfg_shift(cfg_shift),
        .cfg_shift_en(cfg_shift_en), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    function automatic int ratio_val(input int code);
        case (code)
            0: return 5;
            1: return 7;
            2: return 11;
            3: return 13;
            4: return 16;
            5: return 17;
            6: return 19;
            default: return 27;
        endcase
    endfunction

    function automatic int point_of(input int r, input int sh, input bit en);
        int p;
        p = (r - 1) / 2 + (en ? sh : 0);
        if (p < 0) p = 0;
        if (p > r - 1) p = r - 1;
        return p;
    endfunction

    // Value seen at sample index p when a bit is driven wrong for part of its slots.
    function automatic bit seen(input bit v, input int p, input int split, input bit early);
        if (early) return (p < split) ? v : ~v;
        return (p >= split) ? v : ~v;
    endfunction

    // Drive one tick slot: change the line half a clock after a tick.
    task automatic drive_tick(input bit v);
        @(negedge clk);
        rxd = v;
        while (!smp_en) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic drive_bit(input bit v, input int r, input int split, input bit early);
        for (int j = 0; j < r; j++)
            drive_tick((early ? (j < split) : (j >= split)) ? v : ~v);
    endtask

    task automatic send(input logic [7:0] dv, input int code, input bit len7,
                        input bit pen, input bit odd, input bit st2,
                        input int sh, input bit shen, input bit bad_par,
                        input bit s1, input bit s2, input int split, input bit early,
                        input bit chg, input bit expect_it, input string tag);
        int r, p, n;
        bit pb, pacc, sx;
        exp_t e;
        @(negedge clk);
        cfg_ratio = 3'(code); cfg_len7 = len7; cfg_par_en = pen; cfg_par_odd = odd;
        cfg_stop2 = st2; cfg_shift = 4'(sh); cfg_shift_en = shen;
        r = ratio_val(code);
        p = point_of(r, sh, shen);
        n = len7 ? 7 : 8;
        pacc = 1'b0;
        for (int i = 0; i < n; i++) pacc ^= dv[i];
        pb = odd ? ~pacc : pacc;
        if (bad_par) pb = ~pb;
        e.d = 8'h00;
        sx = 1'b0;
        for (int i = 0; i < n; i++) begin
            e.d[i] = seen(dv[i], p, split, early);
            sx ^= e.d[i];
        end
        if (pen | odd) sx ^= seen(pb, p, split, early);
        e.perr = (pen | odd) && (sx != odd);
        e.ferr = !s1 || (st2 && !s2);
        if (expect_it) begin
            expq.push_back(e);
            tagq.push_back(tag);
        end
        repeat (r) drive_tick(1'b0);
        if (chg) begin
            @(negedge clk);
            cfg_ratio = 3'd0; cfg_len7 = ~len7; cfg_par_en = ~pen; cfg_stop2 = ~st2;
        end
        for (int i = 0; i < n; i++) drive_bit(dv[i], r, split, early);
        if (pen | odd) drive_bit(pb, r, split, early);
        repeat (r) drive_tick(s1);
        if (st2) repeat (r) drive_tick(s2);
        repeat (4) drive_tick(1'b1);
    endtask

    // Monitor: pop and compare on every strobe.
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            exp_t  e;
            string t;
            nvalid++;
            if (expq.size() == 0) begin
                check(1'b0, "R8", "unexpected strobe", 1, 0);
            end else begin
                e = expq.pop_front();
                t = tagq.pop_front();
                check(rx_data == e.d, t, "R4 data", int'(rx_data), int'(e.d));
                check(rx_perr == e.perr, t, "R5 parity flag", int'(rx_perr), int'(e.perr));
                check(rx_ferr == e.ferr, t, "R6 framing flag", int'(rx_ferr), int'(e.ferr));
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int snap;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(rx_valid == 1'b0, "R7", "reset strobe", int'(rx_valid), 0);
        check(rx_data == 8'h00, "R7", "reset data", int'(rx_data), 0);
        check(rx_perr == 1'b0 && rx_ferr == 1'b0, "R7", "reset flags",
              int'({rx_perr, rx_ferr}), 0);
        rst_n = 1'b1;
        rx_en = 1'b1;
        repeat (200) drive_tick(1'b1);

        // R1 R4: plain 8N1 at ratio 16
        send(8'hA5, 4, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 1, "R1");
        // R5: ratio 5, even parity, correct
        send(8'h3C, 0, 0, 1, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 1, "R5");
        // R5: ratio 27, odd parity, corrupted parity bit
        send(8'h96, 7, 0, 0, 1, 0, 0, 0, 1, 1, 1, 0, 0, 0, 1, "R5");
        // R4: 7-bit character at ratio 7, MSB must read 0
        send(8'hD5, 1, 1, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 1, "R4");
        // R6: two stop bits, first one low
        send(8'h0F, 2, 0, 0, 0, 1, 0, 0, 0, 0, 1, 0, 0, 0, 1, "R6");
        // R6: two stop bits, second one low, even parity
        send(8'hF0, 3, 0, 1, 0, 1, 0, 0, 0, 1, 0, 0, 0, 0, 1, "R6");
        // R3: ratio 17, +7 shift enabled, bits valid only from index 14
        send(8'h6B, 5, 0, 0, 0, 0, 7, 1, 0, 1, 1, 14, 0, 0, 1, "R3");
        // R3: same line, shift disabled, centre sample reads inverted bits
        send(8'h6B, 5, 0, 0, 0, 0, 7, 0, 0, 1, 1, 14, 0, 0, 1, "R3");
        // R3: ratio 5, -8 clamps to index 0, bits valid only at index 0
        send(8'h2D, 0, 0, 1, 1, 0, -8, 1, 0, 1, 1, 1, 1, 0, 1, "R3");
        // R3: ratio 5, +7 clamps to index 4, bits valid only at index 4
        send(8'hC3, 0, 0, 0, 0, 0, 7, 1, 0, 1, 1, 4, 0, 0, 1, "R3");

        // R2: one-tick glitch at ratio 19 is rejected
        @(negedge clk);
        cfg_ratio = 3'd6; cfg_shift_en = 1'b0;
        snap = nvalid;
        drive_tick(1'b0);
        repeat (60) drive_tick(1'b1);
        check(nvalid == snap, "R2", "glitch produced output", nvalid - snap, 0);
        send(8'h81, 6, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 1, "R2");

        // R10: config flipped after the start bit must not matter
        send(8'hE7, 4, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 1, 1, "R10");

        // R8: receiver disabled
        @(negedge clk);
        rx_en = 1'b0;
        snap = nvalid;
        send(8'h5A, 4, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, "R8");
        check(nvalid == snap, "R8", "output while disabled", nvalid - snap, 0);

        // R9: start too soon after enable is ignored, later one accepted
        @(negedge clk);
        rx_en = 1'b1;
        snap = nvalid;
        send(8'h33, 4, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, "R9");
        check(nvalid == snap, "R9", "output before idle guard", nvalid - snap, 0);
        repeat (170) drive_tick(1'b1);
        send(8'h33, 4, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 1, "R9");

        repeat (10) drive_tick(1'b1);
        check(expq.size() == 0, "R7", "characters never delivered", expq.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule